// File: doc/BRIEF.md
# Metadata-Keyed Cache Controller with Microcoded Dispatch

This block is a small cache for a domain-specific datapath. Entries are found by an application key, such as a packed row/column index pair, and never by a memory address. Each entry holds its key and a walker state. The datapath sends events: an access (a hit or a miss, decided by the tag store), or an explicit preload or evict command. The entry's state and the event code select a cell of a routing table. That cell points at a routine in a small microcode store. A one-op-per-cycle sequencer then runs the routine. It issues memory reads, waits for the replies, writes data sectors, stores the key, sets the next state and returns a response. A single miss routine can fetch every sector of an entry, so one miss fills the whole entry.

The event input is valid/ready. An idle controller accepts any event. While a routine is running, events are held off with `ev_ready` low, with one exception: an access that hits a different entry is answered straight from the data store. A held event must stay stable until the controller accepts it. The response output is a one-cycle valid pulse with no back-pressure, so the datapath must always take it. The memory request port is valid/ready, and a request holds its key, sector and ID until it is accepted. Memory replies carry the ID back and are always accepted. The routing table and the microcode store are written through a plain configuration port.

Top module: `metatag_cache`

## Requirements
- R1: An entry's index is the low log2(ENTRIES) bits of the key. An access hits only when that entry's state is nonzero and its stored key equals the full event key. A different key at the same index is a miss.
- R2: The event code is 0 for an access hit, 1 for an access miss, 2 for a preload command (`ev_cmd`=1) and 3 for an evict command (`ev_cmd`=2). An access has `ev_cmd`=0. The routing cell index is {state, event code}, and the routine starts at the microcode address stored in that cell.
- R3: A microcode word is {opcode[2:0], arg}. The opcodes are: 0 error, 1 memory read of sector arg, 2 wait for the reply, 3 write the key into the tag, 4 write the last reply into sector arg, 5 set the pending state to arg, 6 respond, 7 done. Each op takes one cycle, except 1 (held while not ready) and 2 (held until the reply arrives).
- R4: The key written by a routine is used by later hit checks. A response carries the event key and the full sector word (BANKS words) for the event's sector.
- R5: Each memory request carries the key, the sector and ID = entry index. A routine that reads all sectors makes SECTORS requests for one miss. A request that is not accepted keeps its fields unchanged.
- R6: An access that hits returns the stored sector and issues no memory request.
- R7: While a routine runs, `ev_ready` is low for any event to that entry. An access that hits a different entry is accepted and answered.
- R8: After reset, every routing cell holds 0 and every microcode word is 0. Opcode 0 sets a sticky `err_flag` and ends the routine. The entry state does not change and no response is sent.
- R9: Configuration writes (`cfg_table`=1 for the routing table, 0 for microcode) take effect only when no routine is running. Otherwise they are ignored.
- R10: After reset, `ev_ready` is high and `rsp_valid`, `mem_req_valid` and `err_flag` are low.
- R11: An evict command whose routine sets state 0 makes the next access to that key miss and refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event valid |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_cmd | input | 2 | 0 access, 1 preload, 2 evict |
| ev_key | input | KEY_W | Metadata key |
| ev_sector | input | SEC_W | Sector addressed by the event |
| rsp_valid | output | 1 | Response pulse |
| rsp_key | output | KEY_W | Key of the responding event |
| rsp_data | output | BANKS*WORD_W | Sector contents |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_key | output | KEY_W | Key to fetch |
| mem_req_sector | output | SEC_W | Sector to fetch |
| mem_req_id | output | IDX_W | Request ID (entry index) |
| mem_rsp_valid | input | 1 | Memory reply valid |
| mem_rsp_id | input | IDX_W | Reply ID |
| mem_rsp_data | input | BANKS*WORD_W | Reply sector data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_table | input | 1 | 1 selects the routing table, 0 the microcode |
| cfg_addr | input | UPC_W | Cell or microcode address |
| cfg_data | input | UW | Pointer or microcode word |
| err_flag | output | 1 | Sticky error from an unlisted routing cell |

## Verification
The first access to an empty entry shows that a miss fetches every sector and returns the right one. Repeated accesses to other sectors of the same key then separate real hits from refills, by counting memory requests. A second key at the same index checks that the whole key is compared and not only the index bits, and an evict followed by an access shows that the state written by a routine decides later hits. With the memory port stalled mid-routine, events to the busy entry, hits to another entry, and configuration writes each show a different part of the stall and bypass rules. An evict to an empty entry exercises the error default and shows that it leaves the entry state unchanged.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [2:0] {
    OP_ERR   = 3'd0,
    OP_MREQ  = 3'd1,
    OP_WAIT  = 3'd2,
    OP_WTAG  = 3'd3,
    OP_WDAT  = 3'd4,
    OP_SETST = 3'd5,
    OP_RESP  = 3'd6,
    OP_DONE  = 3'd7
  } uop_e;

  localparam int OP_W = 3;
  localparam int EV_W = 2;

  localparam logic [1:0] CMD_ACCESS  = 2'd0;
  localparam logic [1:0] CMD_PRELOAD = 2'd1;

  localparam logic [EV_W-1:0] EV_HIT     = 2'd0;
  localparam logic [EV_W-1:0] EV_MISS    = 2'd1;
  localparam logic [EV_W-1:0] EV_PRELOAD = 2'd2;
  localparam logic [EV_W-1:0] EV_EVICT   = 2'd3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mtc_tags.sv
module mtc_tags #(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 16,
  parameter int STATE_W = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KEY_W-1:0]   lk_key,
  output logic [IDX_W-1:0]   lk_idx,
  output logic               lk_hit,
  output logic [STATE_W-1:0] lk_state,
  input  logic               tw_en,
  input  logic [IDX_W-1:0]   tw_idx,
  input  logic [KEY_W-1:0]   tw_key,
  input  logic               sw_en,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic [STATE_W-1:0] sw_state
);
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [STATE_W-1:0] st_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        key_q[e] <= '0;
        st_q[e]  <= '0;
      end else begin
        if (tw_en && tw_idx == IDX_W'(e)) key_q[e] <= tw_key;
        if (sw_en && sw_idx == IDX_W'(e)) st_q[e]  <= sw_state;
      end
    end
  end

  assign lk_idx   = lk_key[IDX_W-1:0];
  assign lk_state = st_q[lk_idx];
  assign lk_hit   = (st_q[lk_idx] != '0) && (key_q[lk_idx] == lk_key);
endmodule

// File: rtl/mtc_route.sv
module mtc_route #(
  parameter int UPC_W  = 5,
  parameter int RT_W   = 4,
  parameter int UW     = 5,
  localparam int UC_DEPTH = 1 << UPC_W,
  localparam int RT_DEPTH = 1 << RT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_table,
  input  logic [UPC_W-1:0] cfg_addr,
  input  logic [UW-1:0]    cfg_data,
  input  logic [RT_W-1:0]  rt_idx,
  output logic [UPC_W-1:0] rt_ptr,
  input  logic [UPC_W-1:0] uc_addr,
  output logic [UW-1:0]    uc_word
);
  logic [UW-1:0]    ucode [UC_DEPTH];
  logic [UPC_W-1:0] route [RT_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < UC_DEPTH; i++) ucode[i] <= '0;
    end else if (cfg_en && !cfg_table) begin
      ucode[cfg_addr] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RT_DEPTH; i++) route[i] <= '0;
    end else if (cfg_en && cfg_table && ((cfg_addr >> RT_W) == '0)) begin
      route[cfg_addr[RT_W-1:0]] <= cfg_data[UPC_W-1:0];
    end
  end

  assign rt_ptr  = route[rt_idx];
  assign uc_word = ucode[uc_addr];
endmodule

// File: rtl/mtc_data.sv
module mtc_data #(
  parameter int ENTRIES = 4,
  parameter int SECTORS = 4,
  parameter int BANKS   = 2,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int DW     = BANKS * WORD_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEC_W-1:0] wr_sec,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [SEC_W-1:0] rd_sec,
  output logic [DW-1:0]    rd_data
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [ENTRIES][SECTORS];
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx][wr_sec] <= wr_data[b*WORD_W +: WORD_W];
    end
    assign rd_data[b*WORD_W +: WORD_W] = mem[rd_idx][rd_sec];
  end
endmodule

// File: rtl/mtc_seq.sv
module mtc_seq import mtc_pkg::*; #(
  parameter int KEY_W   = 16,
  parameter int IDX_W   = 2,
  parameter int SEC_W   = 2,
  parameter int STATE_W = 2,
  parameter int UPC_W   = 5,
  parameter int ARG_W   = 2,
  parameter int DW      = 32,
  localparam int UW     = OP_W + ARG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [KEY_W-1:0]   st_key,
  input  logic [SEC_W-1:0]   st_sec,
  input  logic [IDX_W-1:0]   st_idx,
  input  logic [STATE_W-1:0] st_state,
  input  logic [UPC_W-1:0]   st_ptr,
  output logic [UPC_W-1:0]   uc_addr,
  input  logic [UW-1:0]      uc_word,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [KEY_W-1:0]   mem_req_key,
  output logic [SEC_W-1:0]   mem_req_sector,
  output logic [IDX_W-1:0]   mem_req_id,
  input  logic               mem_rsp_valid,
  input  logic [IDX_W-1:0]   mem_rsp_id,
  input  logic [DW-1:0]      mem_rsp_data,
  output logic               tw_en,
  output logic               sw_en,
  output logic [STATE_W-1:0] sw_state,
  output logic               dw_en,
  output logic [SEC_W-1:0]   dw_sec,
  output logic [DW-1:0]      dw_data,
  output logic               resp_fire,
  output logic               busy,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [KEY_W-1:0]   cur_key,
  output logic [SEC_W-1:0]   cur_sec,
  output logic               err_flag
);
  logic [UPC_W-1:0]   upc;
  logic [STATE_W-1:0] nst;
  logic [DW-1:0]      fill_q;
  uop_e               op;
  logic [ARG_W-1:0]   arg;

  assign op  = uop_e'(uc_word[UW-1:ARG_W]);
  assign arg = uc_word[ARG_W-1:0];
  assign uc_addr = upc;

  assign mem_req_valid  = busy && (op == OP_MREQ);
  assign mem_req_key    = cur_key;
  assign mem_req_sector = arg[SEC_W-1:0];
  assign mem_req_id     = cur_idx;
  assign tw_en          = busy && (op == OP_WTAG);
  assign dw_en          = busy && (op == OP_WDAT);
  assign dw_sec         = arg[SEC_W-1:0];
  assign dw_data        = fill_q;
  assign sw_en          = busy && (op == OP_DONE);
  assign sw_state       = nst;
  assign resp_fire      = busy && (op == OP_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      upc      <= '0;
      nst      <= '0;
      fill_q   <= '0;
      cur_idx  <= '0;
      cur_key  <= '0;
      cur_sec  <= '0;
      err_flag <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      upc     <= st_ptr;
      cur_key <= st_key;
      cur_sec <= st_sec;
      cur_idx <= st_idx;
      nst     <= st_state;
    end else if (busy) begin
      case (op)
        OP_ERR: begin
          err_flag <= 1'b1;
          busy     <= 1'b0;
        end
        OP_DONE: busy <= 1'b0;
        OP_MREQ: if (mem_req_ready) upc <= upc + 1'b1;
        OP_WAIT: begin
          if (mem_rsp_valid && mem_rsp_id == cur_idx) begin
            fill_q <= mem_rsp_data;
            upc    <= upc + 1'b1;
          end
        end
        OP_SETST: begin
          nst <= arg[STATE_W-1:0];
          upc <= upc + 1'b1;
        end
        default: upc <= upc + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/metatag_cache.sv
module metatag_cache import mtc_pkg::*; #(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 16,
  parameter int SECTORS = 4,
  parameter int BANKS   = 2,
  parameter int WORD_W  = 16,
  parameter int STATE_W = 2,
  parameter int UPC_W   = 5,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int ARG_W  = imax(SEC_W, STATE_W),
  localparam int UW     = OP_W + ARG_W,
  localparam int DW     = BANKS * WORD_W,
  localparam int RT_W   = STATE_W + EV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [1:0]       ev_cmd,
  input  logic [KEY_W-1:0] ev_key,
  input  logic [SEC_W-1:0] ev_sector,
  output logic             rsp_valid,
  output logic [KEY_W-1:0] rsp_key,
  output logic [DW-1:0]    rsp_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [KEY_W-1:0] mem_req_key,
  output logic [SEC_W-1:0] mem_req_sector,
  output logic [IDX_W-1:0] mem_req_id,
  input  logic             mem_rsp_valid,
  input  logic [IDX_W-1:0] mem_rsp_id,
  input  logic [DW-1:0]    mem_rsp_data,
  input  logic             cfg_we,
  input  logic             cfg_table,
  input  logic [UPC_W-1:0] cfg_addr,
  input  logic [UW-1:0]    cfg_data,
  output logic             err_flag
);
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_hit;
  logic [STATE_W-1:0] lk_state;
  logic [EV_W-1:0]    ev_code;
  logic [UPC_W-1:0]   rt_ptr;
  logic [UPC_W-1:0]   uc_addr;
  logic [UW-1:0]      uc_word;
  logic               seq_busy;
  logic               seq_start;
  logic               tw_en, sw_en, dw_en, resp_fire;
  logic [STATE_W-1:0] sw_state;
  logic [SEC_W-1:0]   dw_sec;
  logic [DW-1:0]      dw_data;
  logic [IDX_W-1:0]   cur_idx;
  logic [KEY_W-1:0]   cur_key;
  logic [SEC_W-1:0]   cur_sec;
  logic               byp_ok, byp_fire;
  logic [IDX_W-1:0]   rd_idx;
  logic [SEC_W-1:0]   rd_sec;
  logic [DW-1:0]      rd_data;

  mtc_tags #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .STATE_W(STATE_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_key(ev_key), .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_state(lk_state),
    .tw_en(tw_en), .tw_idx(cur_idx), .tw_key(cur_key),
    .sw_en(sw_en), .sw_idx(cur_idx), .sw_state(sw_state)
  );

  always_comb begin
    if (ev_cmd == CMD_ACCESS)       ev_code = lk_hit ? EV_HIT : EV_MISS;
    else if (ev_cmd == CMD_PRELOAD) ev_code = EV_PRELOAD;
    else                            ev_code = EV_EVICT;
  end

  mtc_route #(.UPC_W(UPC_W), .RT_W(RT_W), .UW(UW)) u_route (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_we && !seq_busy), .cfg_table(cfg_table),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rt_idx({lk_state, ev_code}), .rt_ptr(rt_ptr),
    .uc_addr(uc_addr), .uc_word(uc_word)
  );

  // Only plain hits on another entry may overtake a running routine.
  assign byp_ok    = seq_busy && (lk_idx != cur_idx) && (ev_cmd == CMD_ACCESS)
                     && lk_hit && !resp_fire;
  assign ev_ready  = !seq_busy || byp_ok;
  assign seq_start = ev_valid && !seq_busy;
  assign byp_fire  = ev_valid && byp_ok;

  mtc_seq #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SEC_W(SEC_W), .STATE_W(STATE_W),
            .UPC_W(UPC_W), .ARG_W(ARG_W), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .st_key(ev_key), .st_sec(ev_sector), .st_idx(lk_idx),
    .st_state(lk_state), .st_ptr(rt_ptr),
    .uc_addr(uc_addr), .uc_word(uc_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_key(mem_req_key), .mem_req_sector(mem_req_sector),
    .mem_req_id(mem_req_id), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_id(mem_rsp_id), .mem_rsp_data(mem_rsp_data),
    .tw_en(tw_en), .sw_en(sw_en), .sw_state(sw_state),
    .dw_en(dw_en), .dw_sec(dw_sec), .dw_data(dw_data),
    .resp_fire(resp_fire), .busy(seq_busy),
    .cur_idx(cur_idx), .cur_key(cur_key), .cur_sec(cur_sec),
    .err_flag(err_flag)
  );

  assign rd_idx = resp_fire ? cur_idx : lk_idx;
  assign rd_sec = resp_fire ? cur_sec : ev_sector;

  mtc_data #(.ENTRIES(ENTRIES), .SECTORS(SECTORS), .BANKS(BANKS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .wr_en(dw_en), .wr_idx(cur_idx), .wr_sec(dw_sec), .wr_data(dw_data),
    .rd_idx(rd_idx), .rd_sec(rd_sec), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_key   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= resp_fire || byp_fire;
      if (resp_fire || byp_fire) begin
        rsp_key  <= resp_fire ? cur_key : ev_key;
        rsp_data <= rd_data;
      end
    end
  end
endmodule

// File: rtl/metatag_cache_chk.sv
module metatag_cache_chk #(
  parameter int KEY_W = 16,
  parameter int SEC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [1:0]       ev_cmd,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [KEY_W-1:0] mem_req_key,
  input logic [SEC_W-1:0] mem_req_sector,
  input logic             err_flag,
  input logic             seq_busy
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_key) && $stable(mem_req_sector));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_bypass_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && seq_busy |-> ev_cmd == 2'd0);

  assert_req_in_routine_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> seq_busy);

  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> ev_ready);
endmodule

bind metatag_cache metatag_cache_chk #(.KEY_W(KEY_W), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/sim_metatag_cache.sv
module sim_metatag_cache;
  localparam int KEY_W = 16;
  localparam int SEC_W = 2;
  localparam int IDX_W = 2;
  localparam int DW    = 32;
  localparam int UPC_W = 5;
  localparam int UW    = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic ev_valid = 0;
  logic ev_ready;
  logic [1:0] ev_cmd = 0;
  logic [KEY_W-1:0] ev_key = 0;
  logic [SEC_W-1:0] ev_sector = 0;
  logic rsp_valid;
  logic [KEY_W-1:0] rsp_key;
  logic [DW-1:0] rsp_data;
  logic mem_req_valid;
  logic mem_req_ready;
  logic [KEY_W-1:0] mem_req_key;
  logic [SEC_W-1:0] mem_req_sector;
  logic [IDX_W-1:0] mem_req_id;
  logic mem_rsp_valid = 0;
  logic [IDX_W-1:0] mem_rsp_id = 0;
  logic [DW-1:0] mem_rsp_data = 0;
  logic cfg_we = 0;
  logic cfg_table = 0;
  logic [UPC_W-1:0] cfg_addr = 0;
  logic [UW-1:0] cfg_data = 0;
  logic err_flag;

  logic mem_stall = 0;
  assign mem_req_ready = !mem_stall;

  metatag_cache u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, nreq = 0, nrsp = 0;
  bit done = 0;
  logic [47:0] expq[$];

  function automatic logic [31:0] memf(input logic [15:0] k, input logic [1:0] s);
    return {k ^ 16'h5A5A, k + 16'(s) * 16'h0101 + 16'h0011};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: responses may overtake, so match by key.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      int hit_i;
      hit_i = -1;
      nrsp++;
      for (int i = 0; i < expq.size(); i++)
        if (hit_i < 0 && expq[i][47:32] == rsp_key) hit_i = i;
      if (hit_i < 0) begin
        chk(0, "R6 unexpected response", {16'h0, rsp_key, rsp_data}, 0);
      end else begin
        chk(rsp_data == expq[hit_i][31:0], "R4 response data",
            rsp_data, expq[hit_i][31:0]);
        expq.delete(hit_i);
      end
    end
  end

  // Memory model with two-cycle reply latency.
  int cnt = 0;
  logic [KEY_W-1:0] pkey;
  logic [SEC_W-1:0] psec;
  logic [IDX_W-1:0] pid;
  always @(negedge clk) begin
    #5;
    mem_rsp_valid = 0;
    if (!rst_n) cnt = 0;
    else begin
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_id = pid;
          mem_rsp_data = memf(pkey, psec);
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        nreq++;
        pkey = mem_req_key; psec = mem_req_sector; pid = mem_req_id;
        chk(mem_req_id == mem_req_key[1:0], "R5 request id", mem_req_id, mem_req_key[1:0]);
        cnt = 2;
      end
    end
  end

  task automatic cfg_write(input bit tbl, input int addr, input int data);
    @(negedge clk); #1;
    cfg_we = 1; cfg_table = tbl; cfg_addr = UPC_W'(addr); cfg_data = UW'(data);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  function automatic int uw(input int op, input int arg);
    return (op << 2) | arg;
  endfunction

  task automatic send(input logic [1:0] cmd, input logic [15:0] key, input logic [1:0] sec,
                      input bit expect_rsp);
    @(negedge clk); #1;
    ev_valid = 1; ev_cmd = cmd; ev_key = key; ev_sector = sec;
    #1;
    while (!ev_ready) begin @(negedge clk); #2; end
    if (expect_rsp) expq.push_back({key, memf(key, sec)});
    @(posedge clk); #1;
    ev_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(ev_ready == 1, "R10 ready after reset", ev_ready, 1);
    chk(rsp_valid == 0, "R10 no response after reset", rsp_valid, 0);
    chk(mem_req_valid == 0, "R10 no request after reset", mem_req_valid, 0);
    chk(err_flag == 0, "R10 error clear after reset", err_flag, 0);

    // Miss routine at 1: per sector read, wait, write; then tag, state 1, respond, done.
    for (int s = 0; s < 4; s++) begin
      cfg_write(0, 1 + 3*s, uw(1, s));
      cfg_write(0, 2 + 3*s, uw(2, 0));
      cfg_write(0, 3 + 3*s, uw(4, s));
    end
    cfg_write(0, 13, uw(3, 0));
    cfg_write(0, 14, uw(5, 1));
    cfg_write(0, 15, uw(6, 0));
    cfg_write(0, 16, uw(7, 0));
    cfg_write(0, 17, uw(6, 0));
    cfg_write(0, 18, uw(7, 0));
    cfg_write(0, 19, uw(5, 0));
    cfg_write(0, 20, uw(7, 0));
    // R2 cells {state,event}
    cfg_write(1, 1, 1);
    cfg_write(1, 5, 1);
    cfg_write(1, 4, 17);
    cfg_write(1, 7, 19);

    // R5 / R2: miss fills all sectors
    n0 = nreq;
    send(0, 16'h1201, 2, 1);
    idle(60);
    chk(nreq - n0 == 4, "R5 four refills per miss", nreq - n0, 4);

    // R6: hits
    n0 = nreq;
    send(0, 16'h1201, 0, 1);
    send(0, 16'h1201, 3, 1);
    idle(20);
    chk(nreq == n0, "R6 hit without memory traffic", nreq - n0, 0);

    // R1: same index, other key
    n0 = nreq;
    send(0, 16'h3401, 1, 1);
    idle(60);
    chk(nreq - n0 == 4, "R1 conflicting key misses", nreq - n0, 4);
    n0 = nreq;
    send(0, 16'h1201, 0, 1);
    idle(60);
    chk(nreq - n0 == 4, "R1 replaced key misses again", nreq - n0, 4);

    // R11: evict then access refills
    send(2, 16'h1201, 0, 0);
    idle(10);
    n0 = nreq;
    send(0, 16'h1201, 1, 1);
    idle(60);
    chk(nreq - n0 == 4, "R11 evicted entry refills", nreq - n0, 4);

    // R7 / R9: stall a routine on entry 3
    send(0, 16'h5602, 0, 1);
    idle(60);
    mem_stall = 1;
    send(0, 16'h7803, 0, 1);
    idle(5);
    @(negedge clk); #1;
    ev_valid = 1; ev_cmd = 0; ev_key = 16'h0003; ev_sector = 0;
    #1;
    chk(ev_ready == 0, "R7 same entry stalled", ev_ready, 0);
    ev_valid = 0;
    send(0, 16'h5602, 3, 1);
    idle(5);
    chk(expq.size() == 1, "R7 bypass hit answered", expq.size(), 1);
    cfg_write(1, 4, 0);
    @(negedge clk); #1;
    mem_stall = 0;
    idle(60);
    chk(expq.size() == 0, "R7 stalled routine completes", expq.size(), 0);
    send(0, 16'h5602, 1, 1);
    idle(20);
    chk(err_flag == 0, "R9 busy config write ignored", err_flag, 0);
    chk(expq.size() == 0, "R9 hit routine still intact", expq.size(), 0);

    // R8: unlisted cell
    r0 = nrsp;
    send(2, 16'h0000, 0, 0);
    idle(10);
    chk(err_flag == 1, "R8 error flag set", err_flag, 1);
    chk(nrsp == r0, "R8 no response from error routine", nrsp - r0, 0);
    n0 = nreq;
    send(0, 16'h0000, 0, 1);
    idle(60);
    chk(nreq - n0 == 4, "R8 state unchanged, still misses", nreq - n0, 4);
    chk(err_flag == 1, "R8 error flag sticky", err_flag, 1);

    // R9: idle config write applies
    cfg_write(1, 4, 0);
    r0 = nrsp;
    send(0, 16'h5602, 2, 0);
    idle(20);
    chk(nrsp == r0, "R9 idle config write applied", nrsp - r0, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule